// File: doc/BRIEF.md
# PHY Control and Status Register Bank

This block holds the control word set for a storage-interface PHY and a single status word. Each bus write carries a 32-bit word. Its upper 16 bits are a bit-by-bit enable for its lower 16 bits, so software can change one field without first reading the register back. Seven control registers sit at byte offsets 0x00 through 0x18, in steps of 4. One read-only status word sits at 0x20.

The status word has two readiness flags. Each is produced by a counter model that can be synthesized. The calibration flag rises a fixed number of clock cycles after the power-up bit is set. The delay-locked-loop flag rises a number of cycles that depends on the frequency select field, counted after the loop enable is set while power is up. Both flags drop as soon as their controlling bits drop. The trim result and the missing-external-resistor flag come in on input pins and are shown in the status word unchanged.

Top module: `phy_ctrl_bank`

## Requirements
- R1: After reset every control register reads 0, and both the calibration flag and the loop-ready flag are 0.
- R2: A write to a control offset changes bit n only when bit n+16 of the written word is 1. Every bit whose enable is 0 keeps its old value.
- R3: Control registers are 14 bits wide at 0x00, 9 bits at 0x04, 10 bits at 0x08, 0x0C, 0x10 and 0x14, and 13 bits at 0x18. Bits above a register's width always read 0.
- R4: The status word at 0x20 holds the calibration flag in bit 6, the loop-ready flag in bit 5, the trim_code input in bits 4:1 and the ext_res_absent input in bit 0. All other bits read 0.
- R5: Writes to 0x20, to 0x1C, to any offset above 0x20 and to any address that is not a multiple of 4 change no register. Reads of those addresses return 0.
- R6: Bit 0 of register 0x18 is power-up. The calibration flag is 1 from exactly CAL_CYCLES clock edges after the edge that sets this bit.
- R7: The calibration flag reads 0 from the edge that writes the power-up bit to 0.
- R8: Bit 1 of register 0x18 is loop enable. Bits 13:12 of register 0x00 are the frequency select, coded 0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz and 3 = 150 MHz. The loop-ready flag is 1 from exactly LOCK_200, LOCK_50, LOCK_100 or LOCK_150 edges, according to that code, after the edge from which loop enable and power-up are both 1.
- R9: The loop-ready flag reads 0 from the edge that clears either loop enable or power-up.
- R10: The cal_done and dll_ready output pins always equal status bits 6 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| addr | input | ADDR_W | Byte address for both read and write |
| wdata | input | 32 | Write word: enables in bits 31:16, values in bits 15:0 |
| rdata | output | 32 | Read word for addr (combinational when REG_READ = 0) |
| trim_code | input | 4 | Trim result shown in the status word |
| ext_res_absent | input | 1 | External resistor not fitted, shown in the status word |
| cal_done | output | 1 | Calibration flag |
| dll_ready | output | 1 | Loop-ready flag |

## Verification
A write takes effect at the rising edge that samples wr_en. With the default combinational read, the new value can be read half a cycle later. The bench therefore drives on falling edges and compares on the next falling edge.

The calibration and loop-ready flags are due exactly N edges after the enabling write edge. The bench steps one falling edge at a time and checks that the flag is still 0 after edge N-1 and is 1 after edge N, so an off-by-one error in either direction is caught. A flag cleared by a write must read 0 at the first falling edge after that write.

// File: rtl/phy_bank_pkg.sv
package phy_bank_pkg;
   localparam int WORD_W  = 32;
   localparam int HALF_W  = 16;
   localparam int NUM_CTL = 7;

   typedef enum logic [1:0] {
      FS_200 = 2'd0,
      FS_50  = 2'd1,
      FS_100 = 2'd2,
      FS_150 = 2'd3
   } freq_sel_e;

   // bit positions that the timing model decodes
   localparam int PWR_BIT   = 0;
   localparam int LOOP_BIT  = 1;
   localparam int FSEL_LO   = 12;
   localparam int PWR_REG   = 6;
   localparam int FSEL_REG  = 0;

   localparam int STAT_OFF  = 32;

   function automatic int ctl_width(input int idx);
      case (idx)
         0:       return 14;
         1:       return 9;
         6:       return 13;
         default: return 10;
      endcase
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/phyb_masked_reg.sv
module phyb_masked_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wval,
   input  logic [W-1:0] wmask,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   generate
      if (W < 1 || W > 16) begin : g_bad_w
         $error("phyb_masked_reg: W must be 1..16");
      end
      for (genvar gi = 0; gi < W; gi++) begin : g_bit
         assign nxt[gi] = (we && wmask[gi]) ? wval[gi] : q[gi];

         // R2
         masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !wmask[gi]) |=> (q[gi] == $past(q[gi])));
         // R2
         masked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && wmask[gi]) |=> (q[gi] == $past(wval[gi])));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/phyb_ready_timer.sv
module phyb_ready_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] target,
   output logic          ready
);
   logic [CW-1:0] cnt;

   generate
      if (CW < 1) begin : g_bad_cw
         $error("phyb_ready_timer: CW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run)           cnt <= '0;
      else if (cnt < target)   cnt <= cnt + 1'b1;
   end

   assign ready = run && (cnt >= target);

   // R7 R9
   ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> run);
   // R6 R8
   ready_needs_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(run));
   // R6 R8
   ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && run) |=> (ready || !run || (target != $past(target))));
endmodule

// File: rtl/phyb_readmux.sv
module phyb_readmux
   import phy_bank_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter bit REG_READ = 1'b0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [NUM_CTL-1:0][WORD_W-1:0]   ctl_words,
   input  logic [WORD_W-1:0]                stat_word,
   output logic [WORD_W-1:0]                rdata
);
   logic [WORD_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_CTL; i++) begin
         if (addr == ADDR_W'(i * 4)) sel = ctl_words[i];
      end
      if (addr == ADDR_W'(STAT_OFF)) sel = stat_word;
   end

   generate
      if (REG_READ) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= sel;
         end
      end else begin : g_comb
         assign rdata = sel;
      end
   endgenerate
endmodule

// File: rtl/phy_ctrl_bank.sv
module phy_ctrl_bank
   import phy_bank_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int CAL_CYCLES = 16,
   parameter int LOCK_200   = 64,
   parameter int LOCK_150   = 86,
   parameter int LOCK_100   = 128,
   parameter int LOCK_50    = 256,
   parameter bit REG_READ   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [3:0]        trim_code,
   input  logic              ext_res_absent,
   output logic              cal_done,
   output logic              dll_ready
);
   localparam int MAXC = max4(max4(LOCK_200, LOCK_150, LOCK_100, LOCK_50),
                              CAL_CYCLES, 1, 1);
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("phy_ctrl_bank: ADDR_W must reach the status offset");
      end
      if (CAL_CYCLES < 1 || LOCK_200 < 1 || LOCK_150 < 1 ||
          LOCK_100 < 1 || LOCK_50 < 1) begin : g_bad_cnt
         $error("phy_ctrl_bank: cycle counts must be at least 1");
      end
   endgenerate

   logic [NUM_CTL-1:0][WORD_W-1:0] ctl_words;
   logic [WORD_W-1:0]              stat_word;

   generate
      for (genvar gr = 0; gr < NUM_CTL; gr++) begin : g_ctl
         localparam int W = ctl_width(gr);
         logic [W-1:0] q;
         logic         hit;
         assign hit = wr_en && (addr == ADDR_W'(gr * 4));
         phyb_masked_reg #(.W(W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (hit),
            .wval  (wdata[W-1:0]),
            .wmask (wdata[HALF_W + W - 1:HALF_W]),
            .q     (q)
         );
         assign ctl_words[gr] = {{(WORD_W - W){1'b0}}, q};
      end
   endgenerate

   logic      pwr_up, loop_en, loop_run;
   freq_sel_e fsel;
   logic [CW-1:0] lock_tgt;

   assign pwr_up   = ctl_words[PWR_REG][PWR_BIT];
   assign loop_en  = ctl_words[PWR_REG][LOOP_BIT];
   assign loop_run = pwr_up && loop_en;
   assign fsel     = freq_sel_e'(ctl_words[FSEL_REG][FSEL_LO+1:FSEL_LO]);

   always_comb begin
      case (fsel)
         FS_50:   lock_tgt = CW'(LOCK_50);
         FS_100:  lock_tgt = CW'(LOCK_100);
         FS_150:  lock_tgt = CW'(LOCK_150);
         default: lock_tgt = CW'(LOCK_200);
      endcase
   end

   phyb_ready_timer #(.CW(CW)) u_cal (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (pwr_up),
      .target (CW'(CAL_CYCLES)),
      .ready  (cal_done)
   );

   phyb_ready_timer #(.CW(CW)) u_loop (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (loop_run),
      .target (lock_tgt),
      .ready  (dll_ready)
   );

   assign stat_word = {25'd0, cal_done, dll_ready, trim_code, ext_res_absent};

   phyb_readmux #(.ADDR_W(ADDR_W), .REG_READ(REG_READ)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .ctl_words (ctl_words),
      .stat_word (stat_word),
      .rdata     (rdata)
   );

   // R5
   stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(STAT_OFF)) |=> $stable(ctl_words));
   // R7
   cal_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_up |-> !cal_done);
endmodule

// File: tb/tb_phy_ctrl_bank.sv
`timescale 1ns/1ps
module tb_phy_ctrl_bank;
   localparam int CAL = 10, L200 = 20, L150 = 27, L100 = 40, L50 = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  trim_code = '0;
   logic        ext_res_absent = 1'b0;
   logic        cal_done, dll_ready;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [15:0] shadow [7];

   always #2 clk = ~clk;

   phy_ctrl_bank #(.ADDR_W(8), .CAL_CYCLES(CAL), .LOCK_200(L200), .LOCK_150(L150),
                   .LOCK_100(L100), .LOCK_50(L50), .REG_READ(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .trim_code(trim_code), .ext_res_absent(ext_res_absent),
      .cal_done(cal_done), .dll_ready(dll_ready));

   function automatic int wid(input int i);
      return (i == 0) ? 14 : (i == 1) ? 9 : (i == 6) ? 13 : 10;
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a, input logic cf, input logic df);
      if (a[1:0] == 2'b00 && a < 8'h1C) return {16'd0, shadow[a >> 2]};
      if (a == 8'h20) return {25'd0, cf, df, trim_code, ext_res_absent};
      return 32'd0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a[1:0] == 2'b00 && a < 8'h1C) begin
         logic [15:0] m, wm;
         m  = d[31:16];
         wm = 16'((32'd1 << wid(a >> 2)) - 1);
         shadow[a >> 2] = ((shadow[a >> 2] & ~m) | (d[15:0] & m)) & wm;
      end
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic cf, input logic df);
      addr = a;
      #0.5;
      chk(req, rdata, exp_read(a, cf, df));
   endtask

   // after a write edge E0, step edges and check flag goes high at edge n exactly
   task automatic step_flag(input string req, input bit which_dll, input int n, input logic other);
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         if (k >= n - 1) begin
            logic f;
            f = which_dll ? dll_ready : cal_done;
            chk(req, {31'd0, f}, {31'd0, (k >= n)});
            if (k == n) begin
               addr = 8'h20; #0.5;
               chk({req, " R4 R10"}, rdata,
                   which_dll ? exp_read(8'h20, other, 1'b1) : exp_read(8'h20, 1'b1, other));
            end
         end
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] alist [11];
      int fs_list [4];
      int lk_list [4];
      void'($urandom(32'd5150));
      alist = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h06};
      for (int i = 0; i < 7; i++) shadow[i] = '0;
      #9 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int i = 0; i < 10; i++) rd_chk("R1", 8'(i * 4), 1'b0, 1'b0);
      chk("R1 flags", {30'd0, cal_done, dll_ready}, 32'd0);

      // R3 all-ones writes, keep timer bits off
      for (int i = 0; i < 7; i++) begin
         do_write(8'(i * 4), (i == 6) ? 32'hFFFC_FFFF : 32'hFFFF_FFFF);
         rd_chk("R3", 8'(i * 4), 1'b0, 1'b0);
      end

      // R2 directed partial masks
      do_write(8'h00, 32'h00F0_0000);
      rd_chk("R2 clear nibble", 8'h00, 1'b0, 1'b0);
      do_write(8'h08, 32'h0000_0000);
      rd_chk("R2 empty mask", 8'h08, 1'b0, 1'b0);
      do_write(8'h14, 32'h0201_0000);
      rd_chk("R2 two bits", 8'h14, 1'b0, 1'b0);

      // random phase
      for (int it = 0; it < 300; it++) begin
         logic [7:0]  a;
         logic [31:0] d;
         a = alist[$urandom_range(0, 10)];
         d = $urandom;
         if (a == 8'h18) d[17:16] = 2'b00;
         trim_code = 4'($urandom);
         ext_res_absent = 1'($urandom);
         do_write(a, d);
         rd_chk((a == 8'h20 || a == 8'h1C || a == 8'h24 || a == 8'h06) ? "R5 random" : "R2 random",
                alist[$urandom_range(0, 10)], 1'b0, 1'b0);
         if (it % 50 == 0)
            for (int i = 0; i < 10; i++) rd_chk("R3 R4 sweep", 8'(i * 4), 1'b0, 1'b0);
      end

      // R5 ignored writes
      do_write(8'h20, 32'hFFFF_FFFF);
      do_write(8'h1C, 32'hFFFF_FFFF);
      do_write(8'h02, 32'hFFFF_FFFF);
      do_write(8'h24, 32'hFFFF_FFFF);
      for (int i = 0; i < 10; i++) rd_chk("R5", 8'(i * 4), 1'b0, 1'b0);
      rd_chk("R5 misaligned read", 8'h05, 1'b0, 1'b0);

      // R6 calibration
      do_write(8'h18, 32'h0003_0000);
      do_write(8'h18, 32'h0001_0001);
      chk("R6 right after", {31'd0, cal_done}, 32'd0);
      step_flag("R6", 1'b0, CAL, 1'b0);

      // R8 / R9 per frequency code
      fs_list = '{1, 2, 3, 0};
      lk_list = '{L50, L100, L150, L200};
      for (int j = 0; j < 4; j++) begin
         do_write(8'h00, {16'h3000, 2'b00, 2'(fs_list[j]), 12'h000});
         do_write(8'h18, 32'h0002_0002);
         chk("R8 right after", {31'd0, dll_ready}, 32'd0);
         step_flag("R8", 1'b1, lk_list[j], 1'b1);
         do_write(8'h18, 32'h0002_0000);
         chk("R9 loop off", {30'd0, cal_done, dll_ready}, 32'd2);
      end

      // R7 / R9 power drop with loop on
      do_write(8'h18, 32'h0002_0002);
      step_flag("R8 again", 1'b1, L200, 1'b1);
      do_write(8'h18, 32'h0001_0000);
      chk("R7 R9 power off", {30'd0, cal_done, dll_ready}, 32'd0);
      rd_chk("R7 status", 8'h20, 1'b0, 1'b0);
      // power back: loop counts from this edge too
      do_write(8'h18, 32'h0001_0001);
      step_flag("R6 again", 1'b0, CAL, 1'b0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule